// File: doc/BRIEF.md
# Parameterised Butterfly Bit-Permutation Unit

This block rearranges or combines the bits of one register-wide word through a fixed butterfly of exchange stages. Stage k pairs every bit j with the bit at j XOR 2^k. Each stage is switched on or off as a whole by one bit of a control amount, so every pair in a stage makes the same decision. The stages are applied from the smallest distance to the largest.

Three functions share the network. Reverse mode replaces each bit with its partner, which covers bit reversal, byte swaps and nibble swaps. OR-combine mode ORs the partner into the bit, which smears set bits across aligned groups. LUT2 mode computes each output bit as any two-input Boolean function of the bit and its partner. Two 4-entry tables are packed in an 8-bit immediate, one for each side of a pair. A zero-source control forces the input word to zero, and LUT2 mode then turns the network into a generator of repeating constant patterns.

The result is registered once. An operation presented in one cycle appears on the output after the next rising clock edge.

Top module: `gbfly_unit`

## Requirements
- R1: A synchronous active-high reset clears the result to zero. Otherwise the result register loads the network output of the inputs present at each rising edge, so the result appears one cycle after the operands.
- R2: Stage k (distance 2^k, k = 0..5) is active exactly when bit k of the amount is 1. Active stages are applied in the order of increasing distance. An amount whose low six bits are zero passes the source through unchanged.
- R3: Function code 0 (reverse) sets bit j of an active stage to its partner bit j XOR 2^k. Amount 63 reverses the bit order of the word, and amount 56 reverses its byte order.
- R4: Function code 1 (OR-combine) sets bit j of an active stage to bit j OR its partner bit.
- R5: Function code 2 (LUT2) sets bit j of an active stage to table entry {partner, self}, where the index is partner*2 + self. Positions with (j AND 2^k) = 0 read the entry from imm[3:0], and all other positions read it from imm[7:4] (entry n is bit n of the nibble).
- R6: Function code 3 behaves exactly as reverse mode.
- R7: Amount bits 6 and 7 are ignored.
- R8: When zero-source is 1, the network input is all zeros. Reverse and OR-combine then yield zero, and LUT2 yields a constant pattern set by the immediate and the amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source word |
| amt_i | input | 8 | Control amount; low 6 bits enable the stages |
| fn_i | input | 2 | Function: 0 reverse, 1 OR-combine, 2 LUT2, 3 reverse |
| imm_i | input | 8 | Two LUT2 tables for LUT2 mode |
| zero_src_i | input | 1 | Force the source word to zero |
| res_o | output | 64 | Registered result |

## Verification
The zero-source path and LUT2 mode can act in the same cycle. This is the case where the unit generates a pattern rather than permutes data. The bench drives both together with single and chained active stages. It compares the result with periodic constants worked out by hand from the table indexing rule, such as 0x5555… after one stage and 0x2222… after two. The bench also raises reset while an operation that would give a nonzero result is on the inputs, and checks that the reset wins.

// File: rtl/gbfly_pkg.sv
package gbfly_pkg;

    typedef enum logic [1:0] {
        FN_REV = 2'd0,
        FN_ORC = 2'd1,
        FN_LUT = 2'd2
    } fn_e;

    // Raw function code to internal function; the spare code maps to reverse
    function automatic fn_e fn_decode(input logic [1:0] code);
        case (code)
            2'd1:    return FN_ORC;
            2'd2:    return FN_LUT;
            default: return FN_REV;
        endcase
    endfunction

    // One output bit of an active stage; hi selects the upper table nibble
    function automatic logic stage_bit(input fn_e fn, input logic [7:0] imm,
                                       input logic hi, input logic self_b,
                                       input logic peer_b);
        case (fn)
            FN_ORC:  return self_b | peer_b;
            FN_LUT:  return imm[{hi, peer_b, self_b}];
            default: return peer_b;
        endcase
    endfunction

endpackage

// File: rtl/gbfly_stage.sv
module gbfly_stage
    import gbfly_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int DIST = 1
) (
    input  logic [XLEN-1:0] x_i,
    input  logic            en_i,
    input  fn_e             fn_i,
    input  logic [7:0]      imm_i,
    output logic [XLEN-1:0] y_o
);

    for (genvar j = 0; j < XLEN; j++) begin : g_bit
        localparam int   PEER = j ^ DIST;
        localparam logic HI   = ((j & DIST) != 0);
        assign y_o[j] = en_i ? stage_bit(fn_i, imm_i, HI, x_i[j], x_i[PEER])
                             : x_i[j];
    end

endmodule

// File: rtl/gbfly_net.sv
module gbfly_net
    import gbfly_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NSTG = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] x_i,
    input  logic [NSTG-1:0] en_i,
    input  fn_e             fn_i,
    input  logic [7:0]      imm_i,
    output logic [XLEN-1:0] y_o
);

    logic [XLEN-1:0] lvl [NSTG+1];

    assign lvl[0] = x_i;

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        gbfly_stage #(
            .XLEN(XLEN),
            .DIST(1 << k)
        ) u_stage (
            .x_i  (lvl[k]),
            .en_i (en_i[k]),
            .fn_i (fn_i),
            .imm_i(imm_i),
            .y_o  (lvl[k+1])
        );
    end

    assign y_o = lvl[NSTG];

endmodule

// File: rtl/gbfly_unit.sv
module gbfly_unit
    import gbfly_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  src_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [1:0]       fn_i,
    input  logic [7:0]       imm_i,
    input  logic             zero_src_i,
    output logic [XLEN-1:0]  res_o
);

    localparam int NSTG = $clog2(XLEN);

    logic [XLEN-1:0] src_eff;
    logic [XLEN-1:0] net_out;
    fn_e             fn_sel;

    assign src_eff = zero_src_i ? '0 : src_i;
    assign fn_sel  = fn_decode(fn_i);

    gbfly_net #(
        .XLEN(XLEN),
        .NSTG(NSTG)
    ) u_net (
        .x_i  (src_eff),
        .en_i (amt_i[NSTG-1:0]),
        .fn_i (fn_sel),
        .imm_i(imm_i),
        .y_o  (net_out)
    );

    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= net_out;
    end

endmodule

// File: rtl/gbfly_chk.sv
module gbfly_chk #(
    parameter int XLEN  = 64,
    parameter int AMT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  src_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [1:0]       fn_i,
    input logic             zero_src_i,
    input logic [XLEN-1:0]  res_o
);

    localparam int NSTG = $clog2(XLEN);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (amt_i[NSTG-1:0] == '0 && !zero_src_i) |=> res_o == $past(src_i)); // R2

    AST_REV_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        (!zero_src_i && (fn_i == 2'd0 || fn_i == 2'd3))
        |=> $countones(res_o) == $countones($past(src_i))); // R3

    AST_ORC_COVERS_SRC: assert property (@(posedge clk) disable iff (rst)
        (!zero_src_i && fn_i == 2'd1) |=> (res_o & $past(src_i)) == $past(src_i)); // R4

    AST_ZERO_NON_LUT: assert property (@(posedge clk) disable iff (rst)
        (zero_src_i && fn_i != 2'd2) |=> res_o == '0); // R8

endmodule

bind gbfly_unit gbfly_chk #(.XLEN(XLEN), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .amt_i     (amt_i),
    .fn_i      (fn_i),
    .zero_src_i(zero_src_i),
    .res_o     (res_o)
);

// File: tb/gbfly_unit_tb.sv
module gbfly_unit_tb;

    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [7:0]  amt = '0;
    logic [1:0]  fn  = '0;
    logic [7:0]  imm = '0;
    logic        zs  = 1'b0;
    logic [63:0] res;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gbfly_unit u_dut (
        .clk(clk), .rst(rst), .src_i(src), .amt_i(amt), .fn_i(fn),
        .imm_i(imm), .zero_src_i(zs), .res_o(res)
    );

    localparam logic [1:0]  V_FN  [NV] = '{0,0,0,0,0,1,1,2,2,2,2,2,3,0,0,1,2,2};
    localparam logic [7:0]  V_AMT [NV] = '{63,56,0,1,32,63,7,63,63,1,2,1,63,127,64,63,1,3};
    localparam logic [7:0]  V_IMM [NV] = '{0,0,0,0,0,0,0,8'hAA,8'hCC,8'hF0,8'h0F,8'h10,0,0,0,0,8'h01,8'h01};
    localparam logic        V_ZS  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,1,1,1};
    localparam logic [63:0] V_SRC [NV] = '{
        64'h1, 64'h0123456789ABCDEF, 64'hDEADBEEFCAFEF00D, 64'h1,
        64'h00000000FFFFFFFF, 64'h1, 64'h100, 64'h0123456789ABCDEF,
        64'h1, 64'h1234, 64'h5678, 64'hFFFF, 64'h1, 64'h1,
        64'hDEADBEEFCAFEF00D, 64'hFFFFFFFFFFFFFFFF, 64'h1234, 64'h1234};
    localparam logic [63:0] V_EXP [NV] = '{
        64'h8000000000000000,   // R3 full reverse
        64'hEFCDAB8967452301,   // R3 byte swap
        64'hDEADBEEFCAFEF00D,   // R2 no stage active
        64'h2,                  // R2 single stage distance 1
        64'hFFFFFFFF00000000,   // R2 distance 32 only
        64'hFFFFFFFFFFFFFFFF,   // R4 OR-combine all stages
        64'h000000000000FF00,   // R4 OR within a byte
        64'h0123456789ABCDEF,   // R5 identity table
        64'h8000000000000000,   // R5 partner table acts as reverse
        64'hAAAAAAAAAAAAAAAA,   // R5 halves use different nibbles
        64'h3333333333333333,   // R5 distance 2 split
        64'hAAAAAAAAAAAAAAAA,   // R8 zero source pattern
        64'h8000000000000000,   // R6 spare code is reverse
        64'h8000000000000000,   // R7 bit 6 ignored
        64'hDEADBEEFCAFEF00D,   // R7 only bit 6 set
        64'h0,                  // R8 zero source OR-combine
        64'h5555555555555555,   // R8 one LUT stage on zeros
        64'h2222222222222222};  // R8 two chained LUT stages on zeros
    localparam int V_REQ [NV] = '{3,3,2,2,2,4,4,5,5,5,5,8,6,7,7,8,8,8};

    task automatic check(input string req, input logic [63:0] exp);
        n_chk++;
        if (res !== exp) begin
            n_err++;
            $display("FAIL %s: res=%h expected=%h", req, res, exp);
        end
    endtask

    task automatic drive(input logic [1:0] f, input logic [7:0] a, input logic [7:0] i,
                         input logic z, input logic [63:0] s);
        @(negedge clk);
        fn = f; amt = a; imm = i; zs = z; src = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset holds the result at zero even with a nonzero operation
        drive(2'd0, 8'd0, 8'd0, 1'b0, 64'hFFFF);
        check("R1", 64'h0);
        @(negedge clk) rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            drive(V_FN[v], V_AMT[v], V_IMM[v], V_ZS[v], V_SRC[v]);
            check($sformatf("R%0d", V_REQ[v]), V_EXP[v]);
        end
        // R1: one-cycle latency, the result follows the previous operands
        drive(2'd0, 8'd63, 8'd0, 1'b0, 64'h2);
        check("R1", 64'h4000000000000000);
        // R1: reset in the middle of a stream wins over a live operation
        @(negedge clk) rst = 1'b1;
        drive(2'd1, 8'd63, 8'd0, 1'b0, 64'h1);
        check("R1", 64'h0);
        @(negedge clk) rst = 1'b0;
        drive(2'd1, 8'd63, 8'd0, 1'b0, 64'h1);
        check("R4", 64'hFFFFFFFFFFFFFFFF);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule